// File: doc/BRIEF.md
# I2C Target for a Mixed-Width Register Map

This block is an I2C target that sits in front of a small register map whose entries are not all the same size. Registers at addresses 0x00 to 0x1C are one byte wide, and the two registers at 0x20 and 0x25 are 32 bits wide. A bus controller writes by sending the target address, a register-pointer byte and then the data bytes, most significant byte first. It reads by writing only the pointer byte and then issuing a repeated START with the read bit set. The target then returns as many bytes as the selected register holds.

SCL and SDA are sampled by the system clock through a synchronizer. START and STOP are recognised from SDA edges while SCL is high. SDA is driven only as an open-drain pull-down enable. A wide register is committed as a unit, and only when all four of its bytes arrive within one transfer, so the logic that consumes the value never sees half of an update. Every stored register value is also presented on parallel ports for the rest of the device. An error-status byte comes in on an input and is returned live whenever it is read.

Top module: `i2c_mixed_regs`

## Requirements
- R1: After reset the parallel outputs hold 0x00=0x6C, 0x03=0xA0, 0x04=0x05, 0x05=0x60, 0x07=0xFF, 0x08..0x0D=0x30, 0x0E=0xB1, 0x10=0x02, 0x18=0x3F, 0x1A=0x18, 0x1B=0x82, 0x1C=0x05, and all other fields are zero. Both wide registers are zero, and SDA is released.
- R2: The target acknowledges only its own 7-bit address (parameter `TARGET_ADDR`, followed by R/W in bit 0, where 1 means read). For any other address it drives nothing and changes no register. It changes its SDA drive only while SCL is low.
- R3: In a write, the first byte after the address selects the register. For a one-byte register, the next byte is stored there and acknowledged.
- R4: A write to 0x20 or 0x25 fills the register most significant byte first. The register is updated only when its fourth data byte arrives in the same transfer. A STOP or START before that point discards the bytes already received.
- R5: After a pointer write and a repeated START read, the target returns one byte for a one-byte register and four bytes, most significant first, for a wide register.
- R6: Addresses 0x0F, 0x11..0x17, 0x1D..0x1F, 0x21..0x24 and everything above 0x25 are holes. The pointer byte selecting a hole is acknowledged, data written to a hole is NACKed and has no effect, and reads from a hole return 0xFF.
- R7: Address 0x01 always reads 0x03. Data written to it is acknowledged and ignored.
- R8: Address 0x02 reads the present value of the `err_status_i` input. Data written to it is acknowledged and ignored.
- R9: The pointer does not auto-increment. Data bytes beyond the selected register's width are NACKed and discarded, and read bytes beyond its width are 0xFF.
- R10: `byte_regs_o[8k+7:8k]` carries the stored value of one-byte register k (k = 0..28), with field 1 fixed at 0x03 and fields 2 and the holes at zero. `wide0_o` carries register 0x20 and `wide1_o` carries register 0x25.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 (open-drain) |
| err_status_i | input | 8 | Live error-status byte returned at 0x02 |
| byte_regs_o | output | 232 | One-byte register values, field k at bits 8k+7:8k |
| wide0_o | output | 32 | Value of wide register 0x20 |
| wide1_o | output | 32 | Value of wide register 0x25 |

## Verification
An SCL edge reaches the protocol engine two clocks after the pin changes. A new SDA drive or a register commit appears on the third clock after the SCL falling edge that ends a byte. The bench changes inputs on the falling clock edge, holds each SCL phase for ten clocks, and samples SDA halfway through the SCL high phase, which is far outside that latency. The reference model updates its register image at the end of each transfer, and the parallel outputs are compared against it on every clock while the bus is idle, from a few clocks after STOP until the next START. During a transfer, the acknowledge bits and the read bytes are compared against values the model derives from the address map.

// File: rtl/i2c_mw_pkg.sv
package i2c_mw_pkg;
  localparam int NARROW_COUNT = 29;
  localparam int WIDE_BYTES   = 4;
  localparam int WIDE_W       = WIDE_BYTES * 8;
  localparam logic [7:0] ID_ADDR  = 8'h01;
  localparam logic [7:0] ID_VAL   = 8'h03;
  localparam logic [7:0] ERR_ADDR = 8'h02;
  localparam logic [7:0] WIDE_A   = 8'h20;
  localparam logic [7:0] WIDE_B   = 8'h25;

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_ACK, ST_RX, ST_TX, ST_MACK} eng_state_t;

  function automatic logic is_wide(input logic [7:0] a);
    return (a == WIDE_A) || (a == WIDE_B);
  endfunction

  function automatic logic is_narrow(input logic [7:0] a);
    return (a < 8'(NARROW_COUNT)) && (a != 8'h0F) && !((a >= 8'h11) && (a <= 8'h17));
  endfunction

  function automatic logic is_hole(input logic [7:0] a);
    return !is_wide(a) && !is_narrow(a);
  endfunction

  function automatic logic is_storable(input logic [7:0] a);
    return is_narrow(a) && (a != ID_ADDR) && (a != ERR_ADDR);
  endfunction

  function automatic logic [7:0] narrow_reset(input logic [7:0] a);
    case (a)
      8'h00: return 8'h6C;
      8'h03: return 8'hA0;
      8'h04, 8'h1C: return 8'h05;
      8'h05: return 8'h60;
      8'h07: return 8'hFF;
      8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D: return 8'h30;
      8'h0E: return 8'hB1;
      8'h10: return 8'h02;
      8'h18: return 8'h3F;
      8'h1A: return 8'h18;
      8'h1B: return 8'h82;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/i2c_mw_sync.sv
module i2c_mw_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int CHAIN = SYNC_STAGES + 1;
  logic [CHAIN-1:0] scl_ff, sda_ff;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
    end else begin
      scl_ff <= {scl_ff[CHAIN-2:0], scl_i};
      sda_ff <= {sda_ff[CHAIN-2:0], sda_i};
    end
  end

  logic scl_q, sda_q;
  assign scl_s     = scl_ff[CHAIN-2];
  assign sda_s     = sda_ff[CHAIN-2];
  assign scl_q     = scl_ff[CHAIN-1];
  assign sda_q     = sda_ff[CHAIN-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_mw_regfile.sv
module i2c_mw_regfile
  import i2c_mw_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      nb_we,
  input  logic [7:0]                nb_addr,
  input  logic [7:0]                nb_data,
  input  logic                      wide_we,
  input  logic                      wide_sel,
  input  logic [WIDE_W-1:0]         wide_data,
  input  logic [7:0]                rd_ptr,
  input  logic [2:0]                rd_idx,
  input  logic [7:0]                err_status_i,
  output logic [7:0]                rd_data,
  output logic [NARROW_COUNT*8-1:0] byte_regs_o,
  output logic [WIDE_W-1:0]         wide0_o,
  output logic [WIDE_W-1:0]         wide1_o
);
  localparam int AW = $clog2(NARROW_COUNT);

  logic [7:0]        mem [NARROW_COUNT];
  logic [WIDE_W-1:0] wide0_q, wide1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NARROW_COUNT; i++) mem[i] <= narrow_reset(8'(i));
    end else if (nb_we && is_storable(nb_addr)) begin
      mem[nb_addr[AW-1:0]] <= nb_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wide0_q <= '0;
      wide1_q <= '0;
    end else if (wide_we) begin
      if (wide_sel) wide1_q <= wide_data;
      else          wide0_q <= wide_data;
    end
  end

  function automatic logic [7:0] pick_byte(input logic [WIDE_W-1:0] w, input logic [2:0] i);
    logic [7:0] r;
    r = 8'hFF;
    for (int k = 0; k < WIDE_BYTES; k++)
      if (int'(i) == k) r = w[(WIDE_BYTES-1-k)*8 +: 8];
    return r;
  endfunction

  always_comb begin
    rd_data = 8'hFF;
    if (rd_ptr == WIDE_A)                      rd_data = pick_byte(wide0_q, rd_idx);
    else if (rd_ptr == WIDE_B)                 rd_data = pick_byte(wide1_q, rd_idx);
    else if (is_narrow(rd_ptr) && rd_idx == 3'd0) begin
      if (rd_ptr == ID_ADDR)                   rd_data = ID_VAL;
      else if (rd_ptr == ERR_ADDR)             rd_data = err_status_i;
      else                                     rd_data = mem[rd_ptr[AW-1:0]];
    end
  end

  for (genvar g = 0; g < NARROW_COUNT; g++) begin : g_out
    if (g == int'(ID_ADDR)) begin : g_id
      assign byte_regs_o[g*8 +: 8] = ID_VAL;
    end else begin : g_mem
      assign byte_regs_o[g*8 +: 8] = mem[g];
    end
  end
  assign wide0_o = wide0_q;
  assign wide1_o = wide1_q;

  // R4: a wide register moves only on a full-width commit from the engine
  assert_wide_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !wide_we |=> ($stable(wide0_q) && $stable(wide1_q)));

  // R6: a write request that may not be stored leaves every byte field as it was
  assert_hole_write_no_effect_R6: assert property (@(posedge clk) disable iff (rst)
    (nb_we && !is_storable(nb_addr)) |=> $stable(byte_regs_o));
endmodule

// File: rtl/i2c_mw_engine.sv
module i2c_mw_engine
  import i2c_mw_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h1B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [7:0]        rd_data,
  output logic              sda_oe,
  output logic [7:0]        ptr,
  output logic [2:0]        idx,
  output logic              nb_we,
  output logic [7:0]        nb_data,
  output logic              wide_we,
  output logic              wide_sel,
  output logic [WIDE_W-1:0] wide_data
);
  eng_state_t        state;
  logic [3:0]        cnt;
  logic [7:0]        sr, tx;
  logic              rd_mode, ptr_set;
  logic [WIDE_W-1:0] wbuf;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; cnt <= '0; sr <= '0; tx <= '0; rd_mode <= 1'b0;
      ptr_set <= 1'b0; ptr <= '0; idx <= '0; wbuf <= '0; sda_oe <= 1'b0;
      nb_we <= 1'b0; nb_data <= '0; wide_we <= 1'b0; wide_sel <= 1'b0; wide_data <= '0;
    end else begin
      nb_we   <= 1'b0;
      wide_we <= 1'b0;
      if (start_det) begin
        state <= ST_ADDR; cnt <= '0; sda_oe <= 1'b0; idx <= '0; ptr_set <= 1'b0;
      end else if (stop_det) begin
        state <= ST_IDLE; sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              sr <= {sr[6:0], sda_s}; cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (sr[7:1] == TARGET_ADDR) begin
                sda_oe <= 1'b1; rd_mode <= sr[0]; state <= ST_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rd_mode) begin
                tx <= rd_data; sda_oe <= ~rd_data[7]; state <= ST_TX;
              end else begin
                sda_oe <= 1'b0; state <= ST_RX;
              end
            end
          end
          ST_RX: begin
            if (scl_rise) begin
              sr <= {sr[6:0], sda_s}; cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              state  <= ST_ACK;
              sda_oe <= 1'b0;
              if (!ptr_set) begin
                ptr <= sr; ptr_set <= 1'b1; idx <= '0; sda_oe <= 1'b1;
              end else if (is_wide(ptr)) begin
                if (idx < 3'(WIDE_BYTES)) begin
                  wbuf   <= {wbuf[WIDE_W-9:0], sr};
                  idx    <= idx + 3'd1;
                  sda_oe <= 1'b1;
                  if (idx == 3'(WIDE_BYTES - 1)) begin
                    wide_we   <= 1'b1;
                    wide_sel  <= (ptr == WIDE_B);
                    wide_data <= {wbuf[WIDE_W-9:0], sr};
                  end
                end
              end else if (is_narrow(ptr) && idx == 3'd0) begin
                nb_we <= 1'b1; nb_data <= sr; idx <= 3'd1; sda_oe <= 1'b1;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0; state <= ST_MACK;
              end else begin
                tx <= {tx[6:0], 1'b1}; sda_oe <= ~tx[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              if (sda_s) state <= ST_IDLE;
              else if (idx != 3'd7) idx <= idx + 3'd1;
            end else if (scl_fall) begin
              cnt <= '0; tx <= rd_data; sda_oe <= ~rd_data[7]; state <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: SDA drive never moves while SCL is high, except for the release after START/STOP
  assert_oe_stable_scl_high_R2: assert property (@(posedge clk) disable iff (rst)
    (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

  // R9: while sending bytes beyond a wide register's width the target never pulls SDA low
  assert_past_width_released_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TX && idx >= 3'(WIDE_BYTES)) |-> !sda_oe);
endmodule

// File: rtl/i2c_mixed_regs.sv
module i2c_mixed_regs
  import i2c_mw_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h1B,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      scl_i,
  input  logic                      sda_i,
  output logic                      sda_oe_o,
  input  logic [7:0]                err_status_i,
  output logic [NARROW_COUNT*8-1:0] byte_regs_o,
  output logic [WIDE_W-1:0]         wide0_o,
  output logic [WIDE_W-1:0]         wide1_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] rd_data, ptr, nb_data;
  logic [2:0] idx;
  logic nb_we, wide_we, wide_sel;
  logic [WIDE_W-1:0] wide_data;

  i2c_mw_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  i2c_mw_engine #(.TARGET_ADDR(TARGET_ADDR)) u_engine (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .sda_oe(sda_oe_o), .ptr(ptr), .idx(idx),
    .nb_we(nb_we), .nb_data(nb_data), .wide_we(wide_we), .wide_sel(wide_sel),
    .wide_data(wide_data));

  i2c_mw_regfile u_regs (
    .clk(clk), .rst(rst), .nb_we(nb_we), .nb_addr(ptr), .nb_data(nb_data),
    .wide_we(wide_we), .wide_sel(wide_sel), .wide_data(wide_data),
    .rd_ptr(ptr), .rd_idx(idx), .err_status_i(err_status_i), .rd_data(rd_data),
    .byte_regs_o(byte_regs_o), .wide0_o(wide0_o), .wide1_o(wide1_o));
endmodule

// File: tb/tb_i2c_mixed_regs.sv
module tb_i2c_mixed_regs;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 10;
  localparam int HOLD = 4;
  localparam int NREG = 29;
  localparam logic [6:0] TADDR = 7'h1B;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_bus;
  logic sda_oe;
  logic [7:0] err_in = 8'h00;
  logic [NREG*8-1:0] byte_regs;
  logic [31:0] wide0, wide1;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_mixed_regs #(.TARGET_ADDR(TADDR)) dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .err_status_i(err_in), .byte_regs_o(byte_regs), .wide0_o(wide0), .wide1_o(wide1));

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;
  bit cmp_en = 1'b0;
  logic [7:0] m_nar [NREG];
  logic [31:0] m_w0, m_w1;
  logic [7:0] pay [0:7];

  function automatic logic [7:0] b_rst(input int a);
    if (a >= 8 && a <= 13) return 8'h30;
    case (a)
      0: return 8'h6C;  3: return 8'hA0;  4: return 8'h05;  5: return 8'h60;
      7: return 8'hFF;  14: return 8'hB1; 16: return 8'h02; 24: return 8'h3F;
      26: return 8'h18; 27: return 8'h82; 28: return 8'h05;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit b_hole(input int a);
    if (a == 32 || a == 37) return 1'b0;
    if (a > 28) return 1'b1;
    return (a == 15) || (a >= 17 && a <= 23);
  endfunction

  function automatic logic [7:0] exp_read(input int p, input int k);
    logic [31:0] w;
    if (p == 32 || p == 37) begin
      w = (p == 32) ? m_w0 : m_w1;
      if (k < 4) return w[(3-k)*8 +: 8];
      return 8'hFF;
    end
    if (b_hole(p) || k != 0) return 8'hFF;
    if (p == 1) return 8'h03;
    if (p == 2) return err_in;
    return m_nar[p];
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R10 / R1: parallel outputs against the model on every idle clock
  always @(negedge clk) begin
    if (cmp_en) begin
      for (int i = 0; i < NREG; i++) begin
        logic [7:0] e;
        e = (i == 1) ? 8'h03 : m_nar[i];
        if (byte_regs[i*8 +: 8] !== e) chk(1'b0, "R10 byte field", byte_regs[i*8 +: 8], e);
      end
      chk(wide0 === m_w0 && wide1 === m_w1, "R10 wide outputs", {wide0, wide1}, {m_w0, m_w1});
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wait_clk(HALF); scl_m = 1'b1; wait_clk(HALF); scl_m = 1'b0; wait_clk(HOLD);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wait_clk(HALF); scl_m = 1'b1; wait_clk(HALF/2);
    b = sda_bus; wait_clk(HALF - HALF/2); scl_m = 1'b0; wait_clk(HOLD);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(HALF); scl_m = 1'b1; wait_clk(HALF);
    sda_m = 1'b0; wait_clk(HALF); scl_m = 1'b0; wait_clk(HOLD);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(HALF); scl_m = 1'b1; wait_clk(HALF); sda_m = 1'b1; wait_clk(HALF);
  endtask

  task automatic put_byte(input logic [7:0] b, output bit ack);
    logic r;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(r);
    ack = !r;
  endtask

  task automatic get_byte(input bit m_ack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin get_bit(r); b[i] = r; end
    put_bit(!m_ack);
  endtask

  task automatic wr_txn(input logic [6:0] a7, input int n, input bit abort, input string req);
    bit ack, hit;
    int p;
    cmp_en = 1'b0;
    hit = (a7 == TADDR);
    bus_start();
    put_byte({a7, 1'b0}, ack);
    chk(ack == hit, "R2 address ack", ack, hit);
    p = pay[0];
    for (int j = 0; j < n; j++) begin
      bit e;
      put_byte(pay[j], ack);
      if (!hit)                     e = 1'b0;
      else if (j == 0)              e = 1'b1;
      else if (p == 32 || p == 37)  e = (j <= 4);
      else if (b_hole(p))           e = 1'b0;
      else                          e = (j == 1);
      chk(ack == e, req, ack, e);
    end
    if (abort) bus_start();
    bus_stop();
    if (hit && (!abort || n >= 5)) begin
      if ((p == 32 || p == 37) && n >= 5) begin
        if (p == 32) m_w0 = {pay[1], pay[2], pay[3], pay[4]};
        else         m_w1 = {pay[1], pay[2], pay[3], pay[4]};
      end else if (n >= 2 && !b_hole(p) && p < NREG && p != 1 && p != 2) begin
        m_nar[p] = pay[1];
      end
    end
    wait_clk(8);
    cmp_en = 1'b1;
  endtask

  task automatic rd_txn(input logic [7:0] p, input int n, input string req);
    bit ack;
    logic [7:0] b;
    cmp_en = 1'b0;
    bus_start();
    put_byte({TADDR, 1'b0}, ack);
    chk(ack, "R5 write-phase address ack", ack, 1);
    put_byte(p, ack);
    chk(ack, "R5 pointer byte ack", ack, 1);
    bus_start();
    put_byte({TADDR, 1'b1}, ack);
    chk(ack, "R5 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      get_byte(k != n - 1, b);
      chk(b === exp_read(p, k), req, b, exp_read(p, k));
    end
    bus_stop();
    wait_clk(8);
    cmp_en = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) m_nar[i] = b_rst(i);
    m_w0 = '0; m_w1 = '0;
    wait_clk(6);
    rst = 1'b0;
    wait_clk(3);
    cmp_en = 1'b1;
    // R1 reset state
    chk(byte_regs[7:0] === 8'h6C, "R1 reg 0x00 reset", byte_regs[7:0], 8'h6C);
    chk(byte_regs[14*8 +: 8] === 8'hB1, "R1 reg 0x0E reset", byte_regs[14*8 +: 8], 8'hB1);
    chk(wide0 === 32'h0 && wide1 === 32'h0, "R1 wide reset", {wide0, wide1}, 0);
    chk(sda_oe === 1'b0, "R1 SDA released", sda_oe, 0);
    wait_clk(20);

    // R2 foreign address: NACK, no change
    pay[0] = 8'h07; pay[1] = 8'hAA;
    wr_txn(TADDR ^ 7'h01, 2, 1'b0, "R2 foreign data ack");

    // R3 narrow write, R5 read, R9 read past width
    pay[0] = 8'h07; pay[1] = 8'h5A;
    wr_txn(TADDR, 2, 1'b0, "R3 narrow write ack");
    rd_txn(8'h07, 2, "R5 R9 narrow read");

    // R9 extra byte NACKed and discarded
    pay[0] = 8'h0E; pay[1] = 8'h11; pay[2] = 8'h22;
    wr_txn(TADDR, 3, 1'b0, "R9 extra narrow byte");
    rd_txn(8'h0E, 1, "R3 narrow readback");
    pay[0] = 8'h1C; pay[1] = 8'hC3;
    wr_txn(TADDR, 2, 1'b0, "R3 last narrow reg write");
    rd_txn(8'h1C, 1, "R3 last narrow reg read");

    // R4 full wide write with a fifth byte, R5 four-byte read
    pay[0] = 8'h20; pay[1] = 8'h01; pay[2] = 8'h23; pay[3] = 8'h45; pay[4] = 8'h67; pay[5] = 8'h89;
    wr_txn(TADDR, 6, 1'b0, "R4 R9 wide write acks");
    rd_txn(8'h20, 5, "R5 R9 wide read msb first");

    // R4 short write and aborted write leave 0x25 unchanged
    pay[0] = 8'h25; pay[1] = 8'hAA; pay[2] = 8'hBB;
    wr_txn(TADDR, 3, 1'b0, "R4 short wide write");
    rd_txn(8'h25, 4, "R4 wide unchanged after short write");
    pay[0] = 8'h25; pay[1] = 8'hCC; pay[2] = 8'hDD; pay[3] = 8'hEE;
    wr_txn(TADDR, 4, 1'b1, "R4 aborted wide write");
    rd_txn(8'h25, 4, "R4 wide unchanged after abort");
    pay[0] = 8'h25; pay[1] = 8'hDE; pay[2] = 8'hAD; pay[3] = 8'hBE; pay[4] = 8'hEF;
    wr_txn(TADDR, 5, 1'b0, "R4 full wide write 0x25");
    rd_txn(8'h25, 4, "R4 R5 wide 0x25 readback");

    // R6 holes
    pay[0] = 8'h12; pay[1] = 8'h44;
    wr_txn(TADDR, 2, 1'b0, "R6 hole write nack");
    rd_txn(8'h12, 1, "R6 hole read");
    pay[0] = 8'h22; pay[1] = 8'h44;
    wr_txn(TADDR, 2, 1'b0, "R6 hole 0x22 write nack");
    rd_txn(8'h30, 2, "R6 hole 0x30 read");

    // R7 identification register
    pay[0] = 8'h01; pay[1] = 8'h55;
    wr_txn(TADDR, 2, 1'b0, "R7 id write ack");
    rd_txn(8'h01, 1, "R7 id read");

    // R8 live error status
    err_in = 8'h9C;
    rd_txn(8'h02, 1, "R8 live status read");
    err_in = 8'h41;
    pay[0] = 8'h02; pay[1] = 8'h77;
    wr_txn(TADDR, 2, 1'b0, "R8 status write ack");
    rd_txn(8'h02, 1, "R8 status after write and change");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog (all requirements) actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule